// File: doc/BRIEF.md
# Busy-Aware Trigger Distributor

This block takes a single interaction trigger and spreads it over a set of detector readout channels. Each channel has a live busy input. A channel receives a one-clock trigger pulse only when it is not busy in the same cycle as the incoming trigger. Channels are gathered into programmable clusters, so a chosen set of detectors is read out together. Every cluster can thin its own trigger stream by a prescale factor, which suits slow detector combinations.

A global downscaler sits in front of the clusters. It thins all interaction triggers whenever the acquisition side reports that it is not fully active. For each channel, a saturating counter of accepted triggers and a saturating counter of triggers refused because of busy can be read through a channel select port. Cluster membership, prescale factors, the downscale factor and the enable bits are loaded through a plain write-enable and address port.

Top module: `trig_fanout`

## Requirements
- R1: A channel that belongs to an enabled cluster, whose cluster passes the trigger and whose `busy_in` bit is low in the trigger cycle, has its `trig_out` bit high in the cycle after `trig_in` is high.
- R2: A channel whose `busy_in` bit is high in the trigger cycle gets no pulse for that interaction.
- R3: Each `trig_out` bit is high for exactly one clock per accepted interaction, and it stays low in every cycle that does not follow a `trig_in` cycle.
- R4: Only channels that belong to at least one enabled cluster can be triggered. A passing cluster triggers all of its non-busy members together, and the result for a channel is the OR over all clusters.
- R5: A cluster prescale of 0 or 1 passes every trigger. A value P > 1 passes only the P-th, 2P-th and so on eligible trigger. A trigger is eligible for a cluster only if it survives the global downscale and reaches at least one non-busy member. Triggers that are not eligible leave the prescale count unchanged.
- R6: When `daq_full` is low, the downscale enable is set and the factor D > 1, only every D-th incoming trigger goes on and the others are dropped. While `daq_full` is high, every trigger goes on and the downscale count returns to zero.
- R7: The accepted counter of a channel goes up by one for each pulse on its `trig_out` bit and holds at its all-ones value. It has CNT_W bits, 32 by default.
- R8: The suppressed counter of a channel goes up by one for each trigger that survives the downscale while the channel is busy and belongs to an enabled cluster. It saturates at all-ones.
- R9: A synchronous reset, `rst` high, does the following: it clears both counters of every channel, drives `trig_out` low, empties every cluster, sets every prescale and the downscale factor to 1, and clears all enable bits.
- R10: Configuration writes take effect on the clock edge where `cfg_we` is high, using this address map. Address k (k < N_CL) holds the member mask of cluster k (bit i = channel i). Address N_CL+k holds the prescale of cluster k. Address 2*N_CL holds the downscale factor. Address 2*N_CL+1 holds the enables: bit k enables cluster k and bit N_CL enables the downscaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_in | input | 1 | Interaction trigger, one cycle per interaction |
| busy_in | input | N_CH | Busy flag per channel |
| daq_full | input | 1 | Acquisition side fully active |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | AW | Configuration register address |
| cfg_wdata | input | CFG_W | Configuration write data |
| cnt_sel | input | CSW | Channel whose counters are shown |
| trig_out | output | N_CH | Trigger pulse per channel |
| acc_cnt | output | CNT_W | Accepted count of the selected channel |
| sup_cnt | output | CNT_W | Busy-suppressed count of the selected channel |

## Verification
On every cycle, the assertions check that no busy channel is pulsed, that no pulse appears without a preceding trigger, and that both counters of the selected channel only ever step up by zero or one. The bench's scenarios are the only way to show the cluster-level behaviour: prescale ordering, prescale counts that freeze while a cluster is fully busy, the downscale pattern and its clearing by `daq_full`, enabling a cluster, saturation, and reset clearing of the configuration.

// File: rtl/trig_fanout.sv
module trig_fanout #(
  parameter int N_CH  = 8,
  parameter int N_CL  = 4,
  parameter int PS_W  = 8,
  parameter int CNT_W = 32,
  parameter int CFG_W = 32,
  localparam int AW   = $clog2(2*N_CL+2),
  localparam int CSW  = $clog2(N_CH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_in,
  input  logic [N_CH-1:0]  busy_in,
  input  logic             daq_full,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic [CSW-1:0]   cnt_sel,
  output logic [N_CH-1:0]  trig_out,
  output logic [CNT_W-1:0] acc_cnt,
  output logic [CNT_W-1:0] sup_cnt
);
  localparam logic [AW-1:0] A_DS = AW'(2*N_CL);
  localparam logic [AW-1:0] A_EN = AW'(2*N_CL+1);

  logic [N_CH-1:0]  mask_q [N_CL];
  logic [PS_W-1:0]  ps_q   [N_CL];
  logic [PS_W-1:0]  pc_q   [N_CL];
  logic [N_CH-1:0]  live   [N_CL];
  logic [N_CL-1:0]  elig, fire;
  logic [N_CL-1:0]  cl_en_q;
  logic             ds_en_q;
  logic [PS_W-1:0]  ds_q, dc_q;
  logic             ds_act, ds_hit, gtrig;
  logic [N_CH-1:0]  fan, member;
  logic [CNT_W-1:0] acc_q [N_CH];
  logic [CNT_W-1:0] sup_q [N_CH];

  assign ds_act = ds_en_q & ~daq_full & (ds_q > PS_W'(1));
  assign ds_hit = dc_q >= ds_q - PS_W'(1);
  assign gtrig  = trig_in & (~ds_act | ds_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      ds_q    <= PS_W'(1);
      ds_en_q <= 1'b0;
      cl_en_q <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == A_DS) ds_q <= cfg_wdata[PS_W-1:0];
      if (cfg_addr == A_EN) begin
        cl_en_q <= cfg_wdata[N_CL-1:0];
        ds_en_q <= cfg_wdata[N_CL];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !ds_act) dc_q <= '0;
    else if (trig_in)   dc_q <= ds_hit ? '0 : dc_q + PS_W'(1);
  end

  for (genvar k = 0; k < N_CL; k++) begin : g_cl
    logic hit;
    assign live[k] = mask_q[k] & ~busy_in;
    assign elig[k] = gtrig & cl_en_q[k] & (|live[k]);
    assign hit     = (ps_q[k] <= PS_W'(1)) | (pc_q[k] >= ps_q[k] - PS_W'(1));
    assign fire[k] = elig[k] & hit;

    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q[k] <= '0;
        ps_q[k]   <= PS_W'(1);
        pc_q[k]   <= '0;
      end else begin
        if (cfg_we && cfg_addr == AW'(k)) mask_q[k] <= cfg_wdata[N_CH-1:0];
        if (cfg_we && cfg_addr == AW'(N_CL+k)) begin
          ps_q[k] <= cfg_wdata[PS_W-1:0];
          pc_q[k] <= '0;
        end else if (elig[k]) begin
          pc_q[k] <= hit ? '0 : pc_q[k] + PS_W'(1);
        end
      end
    end
  end

  always_comb begin
    fan    = '0;
    member = '0;
    for (int k = 0; k < N_CL; k++) begin
      if (fire[k])    fan    = fan | live[k];
      if (cl_en_q[k]) member = member | mask_q[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) trig_out <= '0;
    else     trig_out <= fan;
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    wire inc_a = fan[i];
    wire inc_s = gtrig & member[i] & busy_in[i];
    always_ff @(posedge clk) begin
      if (rst) begin
        acc_q[i] <= '0;
        sup_q[i] <= '0;
      end else begin
        if (inc_a && acc_q[i] != '1) acc_q[i] <= acc_q[i] + CNT_W'(1);
        if (inc_s && sup_q[i] != '1) sup_q[i] <= sup_q[i] + CNT_W'(1);
      end
    end
  end

  assign acc_cnt = acc_q[cnt_sel];
  assign sup_cnt = sup_q[cnt_sel];
endmodule

module trig_fanout_chk #(
  parameter int N_CH  = 8,
  parameter int CNT_W = 32,
  parameter int CSW   = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             trig_in,
  input logic [N_CH-1:0]  busy_in,
  input logic [N_CH-1:0]  trig_out,
  input logic [CSW-1:0]   cnt_sel,
  input logic [CNT_W-1:0] acc_cnt,
  input logic [CNT_W-1:0] sup_cnt
);
  a_r2_busy_blocks: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((trig_out & $past(busy_in)) == '0));

  a_r3_no_trig_no_pulse: assert property (@(posedge clk) disable iff (rst)
    (|trig_out) |-> $past(trig_in));

  a_r7_acc_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(cnt_sel)) |-> ((acc_cnt - $past(acc_cnt)) <= CNT_W'(1)));

  a_r8_sup_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(cnt_sel)) |-> ((sup_cnt - $past(sup_cnt)) <= CNT_W'(1)));
endmodule

bind trig_fanout trig_fanout_chk #(.N_CH(N_CH), .CNT_W(CNT_W), .CSW(CSW)) u_chk (
  .clk(clk), .rst(rst), .trig_in(trig_in), .busy_in(busy_in),
  .trig_out(trig_out), .cnt_sel(cnt_sel), .acc_cnt(acc_cnt), .sup_cnt(sup_cnt)
);

// File: tb/trig_fanout_tb.sv
module trig_fanout_tb;
  localparam int CW = 4;

  logic       clk = 0;
  logic       rst = 1;
  logic       trig_in = 0;
  logic [7:0] busy_in = 0;
  logic       daq_full = 1;
  logic       cfg_we = 0;
  logic [3:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic [2:0] cnt_sel = 0;
  logic [7:0] trig_out;
  logic [CW-1:0] acc_cnt, sup_cnt;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  trig_fanout #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .trig_in(trig_in), .busy_in(busy_in),
    .daq_full(daq_full), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cnt_sel(cnt_sel), .trig_out(trig_out),
    .acc_cnt(acc_cnt), .sup_cnt(sup_cnt)
  );

  // {tag, busy, daq_full, expected trig_out}
  // cluster0 = 0x0F P=1, cluster1 = 0x30 P=2, cluster2 = 0xC0 disabled, D=2
  localparam logic [20:0] VEC [10] = '{
    {4'd1, 8'h00, 1'b1, 8'h0F},
    {4'd5, 8'h00, 1'b1, 8'h3F},
    {4'd5, 8'h30, 1'b1, 8'h0F},
    {4'd2, 8'h01, 1'b1, 8'h0E},
    {4'd5, 8'h10, 1'b1, 8'h2F},
    {4'd2, 8'hFF, 1'b1, 8'h00},
    {4'd6, 8'h00, 1'b0, 8'h00},
    {4'd6, 8'h00, 1'b0, 8'h0F},
    {4'd6, 8'h0F, 1'b0, 8'h00},
    {4'd6, 8'h0F, 1'b0, 8'h30}
  };

  function automatic string tagname(input int t);
    case (t)
      1: return "R1";
      2: return "R2";
      5: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 4'(a); cfg_wdata = 32'(d);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic fire(input logic [7:0] b, input logic f, output logic [7:0] got);
    @(negedge clk);
    trig_in = 1; busy_in = b; daq_full = f;
    @(negedge clk);
    trig_in = 0;
    got = trig_out;
    @(negedge clk);
    chk("R3", {24'd0, trig_out}, 32'd0);
  endtask

  task automatic cnt(input int ch, input int ea, input int es, input string ra, input string rs);
    @(negedge clk);
    cnt_sel = 3'(ch);
    #1;
    chk(ra, 32'(acc_cnt), 32'(ea));
    chk(rs, 32'(sup_cnt), 32'(es));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R9", {24'd0, trig_out}, 32'd0);
    cnt(0, 0, 0, "R9", "R9");

    wr(0, 'h0F); wr(1, 'h30); wr(2, 'hC0);
    wr(5, 2); wr(8, 2); wr(9, 'h13);

    busy_in = 0;
    repeat (3) @(negedge clk);
    chk("R3", {24'd0, trig_out}, 32'd0);

    for (int r = 0; r < 10; r++) begin
      fire(VEC[r][16:9], VEC[r][8], got);
      chk(tagname(int'(VEC[r][20:17])), {24'd0, got}, {24'd0, VEC[r][7:0]});
    end

    cnt(0, 5, 3, "R7", "R8");
    cnt(4, 2, 3, "R7", "R8");
    cnt(7, 0, 0, "R4", "R8");

    // R10: enable cluster2 through the enable register
    wr(9, 'h17);
    fire(8'h00, 1'b1, got);
    chk("R10", {24'd0, got}, 32'h0000_00CF);
    // R5: prescale 0 is pass-through
    wr(5, 0);
    fire(8'h00, 1'b1, got);
    chk("R5", {24'd0, got}, 32'h0000_00FF);
    cnt(0, 7, 3, "R7", "R8");

    for (int n = 0; n < 12; n++) fire(8'h00, 1'b1, got);
    cnt(0, 15, 3, "R7", "R8");
    for (int n = 0; n < 14; n++) fire(8'hFF, 1'b1, got);
    cnt(0, 15, 15, "R7", "R8");

    // R6: downscale count cleared while daq_full is high
    fire(8'h00, 1'b0, got);
    chk("R6", {24'd0, got}, 32'd0);
    fire(8'h00, 1'b1, got);
    chk("R6", {24'd0, got}, 32'h0000_00FF);
    fire(8'h00, 1'b0, got);
    chk("R6", {24'd0, got}, 32'd0);
    fire(8'h00, 1'b0, got);
    chk("R6", {24'd0, got}, 32'h0000_00FF);

    // R9: reset clears counters and configuration
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    cnt(0, 0, 0, "R9", "R9");
    fire(8'h00, 1'b1, got);
    chk("R9", {24'd0, got}, 32'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule